// File: doc/BRIEF.md
# Shared Address/Data Bus I/O Port Controller

This block manages two 8-bit bidirectional ports whose pins serve two purposes: general-purpose I/O under software control, and an external multiplexed address/data bus. Software reaches three kinds of state through a small synchronous register strobe. It can write the output data registers and the per-port drive-style register, and it can read the sampled pin levels. A bus-select input decides, on each cycle, whether the pins show the software output data or the address/data value of an external memory cycle. The software data is never overwritten by a bus cycle, so it returns to the pins as soon as the bus is released.

Each pin is split into an input level and three enables: a high-side driver, a low-side driver and a weak pullup. In I/O mode each port is driven either push-pull or open-drain. The style is chosen per whole port, never per pin. A port in open-drain mode with a 1 in its output bit leaves the pin floating, so the pin can be used as an input. During a bus cycle both ports are always driven push-pull. Pin levels pass through a two-flop synchronizer and then a capture register, and the capture register is what software reads.

Top module: `adbus_port_ctrl`

## Requirements
- R1: While the internal reset is held, every pin has both drivers off and the weak pullup on. The internal reset is held from the moment `rst_n` goes low until two clock edges after `rst_n` returns high. Outside reset the weak pullup is always off.
- R2: After reset, both output data registers read FFh and the drive-style register reads 00h. A read of any address other than the five mapped ones returns 00h.
- R3: A write strobe to address 1FFCh loads the output data register of the low port, which drives pins 7:0. A write strobe to 1FFDh loads the high port, which drives pins 15:8. Reads at the same addresses return the stored values.
- R4: The drive-style register is at 1FF4h. Bit 7 selects the style of the low port and bit 6 selects the style of the high port: 1 means push-pull and 0 means open-drain. Bits 5:0 are not stored and read as 0.
- R5: In I/O mode (`bus_io_sel`=1) on a push-pull port, an output bit of 1 enables only the high driver and an output bit of 0 enables only the low driver. The high and low drivers of a pin are never on together.
- R6: In I/O mode on an open-drain port, an output bit of 0 enables only the low driver and an output bit of 1 enables neither driver.
- R7: When `bus_io_sel`=0, every pin is driven push-pull from the matching bit of `bus_ad`, whatever the drive-style register holds. The output data registers are left unchanged, and they drive the pins again once `bus_io_sel` returns to 1.
- R8: Addresses 1FFEh (pins 7:0) and 1FFFh (pins 15:8) return the pin levels as seen three clock edges earlier: two synchronizer stages and one capture stage. This holds in every drive configuration. Writes to these addresses have no effect.
- R9: Every pin of a port follows the single style bit of that port. Changing one port's style bit leaves the other port's drive unchanged.
- R10: A read strobe updates `reg_rdata` at the next clock edge. Between read strobes `reg_rdata` holds its value, and write strobes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_stb | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| bus_io_sel | input | 1 | 1 = pins under I/O control, 0 = pins carry the external bus |
| bus_ad | input | 16 | Address/data value for the bus cycle; bits 7:0 low port, bits 15:8 high port |
| pin_in | input | 16 | Sampled pin levels (asynchronous) |
| pin_drv_hi | output | 16 | High-side driver enable per pin |
| pin_drv_lo | output | 16 | Low-side driver enable per pin |
| pin_pull_weak | output | 16 | Weak pullup enable per pin |

## Verification
The bus-drive and open-drain properties assume that `bus_io_sel` and `bus_ad` are stable, known values on every clock edge after reset. They also assume that register strobes arrive only once the internal reset has been released. The bench therefore changes all inputs one nanosecond after a rising edge and waits well past the reset release before its first access. The pin inputs are treated as asynchronous by the design, but the bench drives them on the same schedule. Because of that, the three-edge input latency can be predicted exactly and checked against a shift-register model.

// File: rtl/adbus_port_pkg.sv
package adbus_port_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int NPORT   = 2;
  localparam int PIN_W   = NPORT * DATA_W;

  localparam logic [ADDR_W-1:0] ADR_OUT_LO  = 16'h1FFC;
  localparam logic [ADDR_W-1:0] ADR_OUT_HI  = 16'h1FFD;
  localparam logic [ADDR_W-1:0] ADR_IN_LO   = 16'h1FFE;
  localparam logic [ADDR_W-1:0] ADR_IN_HI   = 16'h1FFF;
  localparam logic [ADDR_W-1:0] ADR_STYLE   = 16'h1FF4;

  localparam int STYLE_BIT_LO = 7;
  localparam int STYLE_BIT_HI = 6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_IN_LO,
    SEL_IN_HI,
    SEL_STYLE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      ADR_OUT_LO: s = SEL_OUT_LO;
      ADR_OUT_HI: s = SEL_OUT_HI;
      ADR_IN_LO:  s = SEL_IN_LO;
      ADR_IN_HI:  s = SEL_IN_HI;
      ADR_STYLE:  s = SEL_STYLE;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/adbus_rst_sync.sv
module adbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/adbus_pin_sync.sv
module adbus_pin_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_int_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = pin_async;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) stage_q <= '0;
    else            stage_q <= stage_d;
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/adbus_pad_drive.sv
module adbus_pad_drive #(
  parameter int WIDTH = 8
) (
  input  logic             run,
  input  logic             io_mode,
  input  logic             push_pull,
  input  logic [WIDTH-1:0] user_data,
  input  logic [WIDTH-1:0] bus_data,
  output logic [WIDTH-1:0] drv_hi,
  output logic [WIDTH-1:0] drv_lo,
  output logic [WIDTH-1:0] pull_weak
);
  logic [WIDTH-1:0] level;
  logic             hi_allowed;

  always_comb begin
    level      = io_mode ? user_data : bus_data;
    hi_allowed = io_mode ? push_pull : 1'b1;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      drv_hi[b]    = run & hi_allowed & level[b];
      drv_lo[b]    = run & ~level[b];
      pull_weak[b] = ~run;
    end
  end
endmodule

// File: rtl/adbus_port_ctrl.sv
module adbus_port_ctrl
  import adbus_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_stb,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bus_io_sel,
  input  logic [PIN_W-1:0]  bus_ad,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_drv_hi,
  output logic [PIN_W-1:0]  pin_drv_lo,
  output logic [PIN_W-1:0]  pin_pull_weak
);
  logic rst_int_n;

  logic [NPORT-1:0][DATA_W-1:0] out_q, out_d;
  logic [NPORT-1:0]             style_q, style_d;
  logic [NPORT-1:0][DATA_W-1:0] in_q;
  logic [DATA_W-1:0]            rdata_q, rdata_d;
  logic [PIN_W-1:0]             pin_s;

  logic     wr_en, rd_en;
  reg_sel_e sel;

  adbus_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  adbus_pin_sync #(.WIDTH(PIN_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_int_n(rst_int_n), .pin_async(pin_in), .pin_sync(pin_s)
  );

  always_comb begin
    sel   = decode_addr(reg_addr);
    wr_en = reg_stb & reg_we;
    rd_en = reg_stb & ~reg_we;
  end

  // Next-state for writable registers
  always_comb begin
    out_d   = out_q;
    style_d = style_q;
    if (wr_en) begin
      case (sel)
        SEL_OUT_LO: out_d[0] = reg_wdata;
        SEL_OUT_HI: out_d[1] = reg_wdata;
        SEL_STYLE: begin
          style_d[0] = reg_wdata[STYLE_BIT_LO];
          style_d[1] = reg_wdata[STYLE_BIT_HI];
        end
        default: ;
      endcase
    end
  end

  // Read data mux
  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      case (sel)
        SEL_OUT_LO: rdata_d = out_q[0];
        SEL_OUT_HI: rdata_d = out_q[1];
        SEL_IN_LO:  rdata_d = in_q[0];
        SEL_IN_HI:  rdata_d = in_q[1];
        SEL_STYLE: begin
          rdata_d = '0;
          rdata_d[STYLE_BIT_LO] = style_q[0];
          rdata_d[STYLE_BIT_HI] = style_q[1];
        end
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_q   <= '1;
      style_q <= '0;
      in_q    <= '0;
      rdata_q <= '0;
    end else begin
      out_q   <= out_d;
      style_q <= style_d;
      in_q    <= pin_s;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    adbus_pad_drive #(.WIDTH(DATA_W)) u_drive (
      .run       (rst_int_n),
      .io_mode   (bus_io_sel),
      .push_pull (style_q[p]),
      .user_data (out_q[p]),
      .bus_data  (bus_ad[p*DATA_W +: DATA_W]),
      .drv_hi    (pin_drv_hi[p*DATA_W +: DATA_W]),
      .drv_lo    (pin_drv_lo[p*DATA_W +: DATA_W]),
      .pull_weak (pin_pull_weak[p*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/adbus_port_chk.sv
module adbus_port_chk
  import adbus_port_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run,
  input logic                         reg_stb,
  input logic                         reg_we,
  input logic [ADDR_W-1:0]            reg_addr,
  input logic [DATA_W-1:0]            reg_wdata,
  input logic                         bus_io_sel,
  input logic [PIN_W-1:0]             bus_ad,
  input logic [PIN_W-1:0]             pin_drv_hi,
  input logic [PIN_W-1:0]             pin_drv_lo,
  input logic [PIN_W-1:0]             pin_pull_weak,
  input logic [NPORT-1:0]             style_q,
  input logic [NPORT-1:0][DATA_W-1:0] out_q
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_safe_R1: assert (pin_pull_weak == '1 && pin_drv_hi == '0 && pin_drv_lo == '0)
        else $error("reset pin state wrong");
    end
  end

  assert_pull_off_R1: assert property (@(posedge clk) disable iff (!run)
    pin_pull_weak == '0);

  assert_no_crossover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_drv_hi & pin_drv_lo) == '0);

  assert_od_lo_port_R6: assert property (@(posedge clk) disable iff (!run)
    (bus_io_sel && !style_q[0]) |-> pin_drv_hi[DATA_W-1:0] == '0);

  assert_od_hi_port_R6: assert property (@(posedge clk) disable iff (!run)
    (bus_io_sel && !style_q[1]) |-> pin_drv_hi[PIN_W-1:DATA_W] == '0);

  assert_bus_drive_R7: assert property (@(posedge clk) disable iff (!run)
    !bus_io_sel |-> (pin_drv_hi == bus_ad && pin_drv_lo == ~bus_ad));

  assert_out_write_R3: assert property (@(posedge clk) disable iff (!run)
    (reg_stb && reg_we && reg_addr == ADR_OUT_LO) |=> out_q[0] == $past(reg_wdata));
endmodule

bind adbus_port_ctrl adbus_port_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run           (rst_int_n),
  .reg_stb       (reg_stb),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .bus_io_sel    (bus_io_sel),
  .bus_ad        (bus_ad),
  .pin_drv_hi    (pin_drv_hi),
  .pin_drv_lo    (pin_drv_lo),
  .pin_pull_weak (pin_pull_weak),
  .style_q       (style_q),
  .out_q         (out_q)
);

// File: tb/adbus_port_ctrl_test.sv
`timescale 1ns/1ps
module adbus_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_stb, reg_we;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        bus_io_sel;
  logic [15:0] bus_ad, pin_in;
  logic [15:0] pin_drv_hi, pin_drv_lo, pin_pull_weak;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  adbus_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_stb(reg_stb), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_io_sel(bus_io_sel), .bus_ad(bus_ad), .pin_in(pin_in),
    .pin_drv_hi(pin_drv_hi), .pin_drv_lo(pin_drv_lo), .pin_pull_weak(pin_pull_weak)
  );

  // Behavioural reference model
  bit       m_r1, m_r2;
  bit [7:0] m_out [2];
  bit [1:0] m_style;
  bit [7:0] m_in [2];
  bit [7:0] m_rd;
  bit [15:0] pin_hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      m_out[0] = 8'hFF; m_out[1] = 8'hFF; m_style = 0;
      m_in[0] = 0; m_in[1] = 0; m_rd = 0;
      pin_hist = '{16'h0, 16'h0};
    end else begin
      if (!m_r2) begin
        m_out[0] = 8'hFF; m_out[1] = 8'hFF; m_style = 0;
        m_in[0] = 0; m_in[1] = 0; m_rd = 0;
        pin_hist = '{16'h0, 16'h0};
      end else begin
        if (reg_stb && !reg_we) begin
          case (reg_addr)
            16'h1FFC: m_rd = m_out[0];
            16'h1FFD: m_rd = m_out[1];
            16'h1FFE: m_rd = m_in[0];
            16'h1FFF: m_rd = m_in[1];
            16'h1FF4: m_rd = {m_style[0], m_style[1], 6'b0};
            default:  m_rd = 0;
          endcase
        end
        if (reg_stb && reg_we) begin
          if (reg_addr == 16'h1FFC) m_out[0] = reg_wdata;
          if (reg_addr == 16'h1FFD) m_out[1] = reg_wdata;
          if (reg_addr == 16'h1FF4) m_style = {reg_wdata[6], reg_wdata[7]};
        end
        m_in[0] = pin_hist[0][7:0];
        m_in[1] = pin_hist[0][15:8];
        void'(pin_hist.pop_front());
        pin_hist.push_back(pin_in);
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done && rst_n !== 1'bx) begin
      logic [15:0] eh, el, ep;
      for (int i = 0; i < 16; i++) begin
        bit v, pp;
        if (!m_r2) begin
          eh[i] = 0; el[i] = 0; ep[i] = 1;
        end else begin
          v  = bus_io_sel ? m_out[i/8][i%8] : bus_ad[i];
          pp = bus_io_sel ? m_style[i/8] : 1'b1;
          eh[i] = v & pp; el[i] = ~v; ep[i] = 0;
        end
      end
      check(cur_req, "drv_hi", pin_drv_hi, eh);
      check(cur_req, "drv_lo", pin_drv_lo, el);
      check(cur_req, "pull_weak", pin_pull_weak, ep);
      check(cur_req, "rdata", {8'h0, reg_rdata}, {8'h0, m_rd});
    end
  end

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    reg_stb = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_stb = 0; reg_we = 0;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] exp, string req);
    @(posedge clk); #1;
    reg_stb = 1; reg_we = 0; reg_addr = a;
    @(posedge clk); #1;
    reg_stb = 0;
    check(req, "read", {8'h0, reg_rdata}, {8'h0, exp});
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; reg_stb = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    bus_io_sel = 1; bus_ad = 0; pin_in = 16'h0;
    idle(4);
    cur_req = "R1";
    check("R1", "reset pull", pin_pull_weak, 16'hFFFF);
    check("R1", "reset hi", pin_drv_hi, 16'h0);
    @(posedge clk); #1 rst_n = 1;
    @(posedge clk); #1;
    check("R1", "still held pull", pin_pull_weak, 16'hFFFF);
    idle(2);
    check("R1", "released pull", pin_pull_weak, 16'h0);

    cur_req = "R2";
    rd(16'h1FFC, 8'hFF, "R2");
    rd(16'h1FFD, 8'hFF, "R2");
    rd(16'h1FF4, 8'h00, "R2");
    rd(16'h1FF0, 8'h00, "R2");
    rd(16'h2000, 8'h00, "R2");

    cur_req = "R6";
    check("R6", "od all ones hi", pin_drv_hi, 16'h0);
    check("R6", "od all ones lo", pin_drv_lo, 16'h0);
    wr(16'h1FFC, 8'hA5);
    #1 check("R6", "od lo port", pin_drv_lo, 16'h005A);
    check("R6", "od hi off", pin_drv_hi, 16'h0);

    cur_req = "R3";
    rd(16'h1FFC, 8'hA5, "R3");
    wr(16'h1FFD, 8'h3C);
    rd(16'h1FFD, 8'h3C, "R3");

    cur_req = "R9";
    wr(16'h1FF4, 8'h80);
    check("R5", "pp lo port hi", pin_drv_hi, 16'h00A5);
    check("R9", "hi port still od", pin_drv_lo[15:8], 16'h00C3);
    check("R9", "hi port no high", pin_drv_hi[15:8], 16'h0);
    cur_req = "R4";
    rd(16'h1FF4, 8'h80, "R4");
    wr(16'h1FF4, 8'h7F);
    rd(16'h1FF4, 8'h40, "R4");
    check("R9", "lo port back od", pin_drv_hi[7:0], 16'h0);
    check("R5", "hi port pp", pin_drv_hi[15:8], 16'h3C);
    wr(16'h1FF4, 8'hFF);
    rd(16'h1FF4, 8'hC0, "R4");
    cur_req = "R5";
    wr(16'h1FFC, 8'h0F);
    check("R5", "pp hi", pin_drv_hi, 16'h3C0F);
    check("R5", "pp lo", pin_drv_lo, 16'hC3F0);

    cur_req = "R7";
    wr(16'h1FF4, 8'h00);
    @(posedge clk); #1 bus_io_sel = 0; bus_ad = 16'h1234;
    #1 check("R7", "bus hi", pin_drv_hi, 16'h1234);
    check("R7", "bus lo", pin_drv_lo, 16'hEDCB);
    wr(16'h1FFC, 8'h99);
    @(posedge clk); #1 bus_ad = 16'hF00D;
    #1 check("R7", "bus hi 2", pin_drv_hi, 16'hF00D);
    @(posedge clk); #1 bus_io_sel = 1;
    #1 check("R7", "restored lo", pin_drv_lo, 16'hC366);
    rd(16'h1FFC, 8'h99, "R7");

    cur_req = "R8";
    @(posedge clk); #1 pin_in = 16'h5AC3;
    @(posedge clk); #1;
    @(posedge clk); #1;
    reg_stb = 1; reg_we = 0; reg_addr = 16'h1FFE;
    @(posedge clk); #1 reg_stb = 0;
    check("R8", "too early", {8'h0, reg_rdata}, 16'h0000);
    rd(16'h1FFE, 8'hC3, "R8");
    rd(16'h1FFF, 8'h5A, "R8");
    wr(16'h1FFE, 8'h00);
    rd(16'h1FFE, 8'hC3, "R8");
    wr(16'h1FF4, 8'hC0);
    @(posedge clk); #1 pin_in = 16'hA55A;
    idle(3);
    rd(16'h1FFF, 8'hA5, "R8");

    cur_req = "R10";
    rd(16'h1FFD, 8'h3C, "R10");
    wr(16'h1FFD, 8'h11);
    idle(3);
    check("R10", "rdata held", {8'h0, reg_rdata}, 16'h003C);
    rd(16'h1FFD, 8'h11, "R10");

    cur_req = "R1";
    @(posedge clk); #1 rst_n = 0;
    #1 check("R1", "async pull", pin_pull_weak, 16'hFFFF);
    check("R1", "async lo", pin_drv_lo, 16'h0);
    idle(2);
    @(posedge clk); #1 rst_n = 1;
    idle(4);
    rd(16'h1FFC, 8'hFF, "R2");

    done = 1;
    summary();
    $finish;
  end
endmodule